// File: doc/BRIEF.md
# DMA Transfer-Request Sequencer with Completion Tagging

This block sequences one DMA channel's work. A start strobe latches a channel configuration: the synchronization mode, the second- and third-dimension counts, a 6-bit completion code, two interrupt enables (final and intermediate) and a completion-timing mode. The block then offers transfer requests one at a time on a valid/ready port. In array-synchronized mode there is one request per array, which gives second count times third count requests. In frame-synchronized mode there is one request per frame, which gives third count requests. Each request is marked as final or intermediate.

For each request, the block can raise a completion event that carries the channel's code. The final enable gates the event for the last request, and the intermediate enable gates the events for all other requests. In early mode the event follows the request's acceptance. In normal mode it follows the transfer controller's done acknowledgement for that request, and the acknowledgements arrive in issue order. The first-dimension size has no effect on sequencing, so it is not an input.

Top module: `dma_tr_sequencer`

## Requirements
- R1: In array-synchronized mode (`cfg_ab_sync`=0), exactly `cfg_bcnt`×`cfg_ccnt` requests are accepted per job (4×5 gives 20).
- R2: In frame-synchronized mode (`cfg_ab_sync`=1), exactly `cfg_ccnt` requests are accepted per job (5 gives 5).
- R3: `tr_last` is 1 on the last request of a job and 0 on every other request.
- R4: With only `cfg_final_en` set, a job produces exactly one event, and it belongs to the last request.
- R5: With only `cfg_inter_en` set, a job produces one event for every request except the last (19 for 4×5 array mode, 4 for frame mode with 5 frames).
- R6: With both enables set, a job produces one event for every request.
- R7: With `cfg_early`=1, `cpl_valid` is high for one cycle, in the cycle that directly follows the clock edge at which the request was accepted, and `tr_done` is ignored.
- R8: With `cfg_early`=0, `cpl_valid` is high for one cycle, directly after the edge at which a `tr_done` pulse acknowledges the oldest unacknowledged request. A `tr_done` pulse while no request is outstanding is ignored.
- R9: `cpl_code` equals the `cfg_code` value latched at start whenever `cpl_valid` is high.
- R10: A start with `cfg_bcnt`=0 or `cfg_ccnt`=0 raises `cfg_err` for one cycle, leaves `busy` low and issues no requests.
- R11: `busy` rises on the edge after a valid start. It falls on the edge that accepts the last request (early mode) or that takes the last acknowledgement (normal mode). A start while `busy` is high has no effect on the running job.
- R12: While `tr_valid` is high and `tr_ready` is low, `tr_valid`, `tr_last` and `tr_code` hold their values into the next cycle.
- R13: After reset, `busy`, `tr_valid`, `cpl_valid` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; latches the configuration when idle |
| cfg_ab_sync | input | 1 | 1: one request per frame; 0: one request per array |
| cfg_bcnt | input | CNT_W | Arrays per frame |
| cfg_ccnt | input | CNT_W | Frames per block |
| cfg_code | input | CODE_W | Completion code carried by events |
| cfg_final_en | input | 1 | Enable the event for the last request |
| cfg_inter_en | input | 1 | Enable events for the other requests |
| cfg_early | input | 1 | 1: event on acceptance; 0: event on acknowledgement |
| tr_valid | output | 1 | Request offered |
| tr_ready | input | 1 | Request taken this cycle when valid |
| tr_last | output | 1 | Offered request is the last of the job |
| tr_code | output | CODE_W | Completion code of the offered request |
| tr_done | input | 1 | Done pulse for the oldest outstanding request |
| busy | output | 1 | Job in progress |
| cfg_err | output | 1 | One-cycle pulse: start with a zero count |
| cpl_valid | output | 1 | Completion event |
| cpl_code | output | CODE_W | Code of the completion event |

## Verification
A wrong issue counter shows up within the job. Either `tr_last` appears on the wrong request, or `tr_valid` stays high after the final one, which adds an accepted request at the next ready cycle. A wrong acknowledgement counter or a mislatched mode shows up one cycle after the affected edge. It appears as a missing, extra or displaced `cpl_valid`, or as `busy` falling too early or too late. The bench compares every cycle against its own model, so any of these is caught in the cycle where it first appears.

// File: rtl/dma_tr_sequencer.sv
module dma_tr_sequencer #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_ab_sync,
  input  logic [CNT_W-1:0]  cfg_bcnt,
  input  logic [CNT_W-1:0]  cfg_ccnt,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cfg_final_en,
  input  logic              cfg_inter_en,
  input  logic              cfg_early,
  output logic              tr_valid,
  input  logic              tr_ready,
  output logic              tr_last,
  output logic [CODE_W-1:0] tr_code,
  input  logic              tr_done,
  output logic              busy,
  output logic              cfg_err,
  output logic              cpl_valid,
  output logic [CODE_W-1:0] cpl_code
);
  localparam int TOT_W = 2 * CNT_W;
  localparam logic [TOT_W-1:0] ONE = TOT_W'(1);

  logic              busy_q, err_q, cpl_q;
  logic              fin_en_q, int_en_q, early_q;
  logic [CODE_W-1:0] code_q, cpl_code_q;
  logic [TOT_W-1:0]  total_q, issued_q, acked_q;

  wire cfg_bad  = (cfg_bcnt == '0) || (cfg_ccnt == '0);
  wire start_ok = start && !busy_q;
  wire [TOT_W-1:0] cfg_total = cfg_ab_sync ? {{CNT_W{1'b0}}, cfg_ccnt}
                             : {{CNT_W{1'b0}}, cfg_bcnt} * {{CNT_W{1'b0}}, cfg_ccnt};

  assign tr_valid = busy_q && (issued_q != total_q);
  assign tr_last  = (issued_q == total_q - ONE);
  assign tr_code  = code_q;

  wire accept   = tr_valid && tr_ready;
  wire ack      = tr_done && busy_q && !early_q && (acked_q != issued_q);
  wire ack_last = (acked_q == total_q - ONE);

  wire fire_early = accept && early_q && (tr_last ? fin_en_q : int_en_q);
  wire fire_norm  = ack && (ack_last ? fin_en_q : int_en_q);
  wire job_end    = early_q ? (accept && tr_last) : (ack && ack_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
      cpl_q      <= 1'b0;
      cpl_code_q <= '0;
      fin_en_q   <= 1'b0;
      int_en_q   <= 1'b0;
      early_q    <= 1'b0;
      code_q     <= '0;
      total_q    <= '0;
      issued_q   <= '0;
      acked_q    <= '0;
    end else begin
      err_q      <= start_ok && cfg_bad;
      cpl_q      <= fire_early || fire_norm;
      cpl_code_q <= code_q;
      if (start_ok && !cfg_bad) begin
        busy_q   <= 1'b1;
        total_q  <= cfg_total;
        code_q   <= cfg_code;
        fin_en_q <= cfg_final_en;
        int_en_q <= cfg_inter_en;
        early_q  <= cfg_early;
        issued_q <= '0;
        acked_q  <= '0;
      end else begin
        if (job_end) busy_q <= 1'b0;
        if (accept)  issued_q <= issued_q + ONE;
        if (ack)     acked_q  <= acked_q + ONE;
      end
    end
  end

  assign busy      = busy_q;
  assign cfg_err   = err_q;
  assign cpl_valid = cpl_q;
  assign cpl_code  = cpl_code_q;

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid && !tr_ready |=> tr_valid && $stable(tr_last) && $stable(tr_code));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tr_valid);

  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && cfg_bcnt != '0 && cfg_ccnt != '0 |=> busy);

  assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && !tr_valid);

  assert_last_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid && tr_ready && tr_last |=> !tr_valid);

  assert_cpl_in_job_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> $past(busy));
endmodule

// File: tb/dma_tr_sequencer_tb.sv
`timescale 1ns/1ps
module dma_tr_sequencer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cfg_ab_sync = 0, cfg_final_en = 0, cfg_inter_en = 0, cfg_early = 0;
  logic [15:0] cfg_bcnt = 0, cfg_ccnt = 0;
  logic [5:0]  cfg_code = 0;
  logic tr_ready = 0, tr_done = 0;
  logic tr_valid, tr_last, busy, cfg_err, cpl_valid;
  logic [5:0] tr_code, cpl_code;
  int checks = 0, errors = 0;
  bit finished_run = 0;

  always #4 clk = ~clk;

  dma_tr_sequencer #(.CNT_W(16), .CODE_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_ab_sync(cfg_ab_sync),
    .cfg_bcnt(cfg_bcnt), .cfg_ccnt(cfg_ccnt), .cfg_code(cfg_code),
    .cfg_final_en(cfg_final_en), .cfg_inter_en(cfg_inter_en), .cfg_early(cfg_early),
    .tr_valid(tr_valid), .tr_ready(tr_ready), .tr_last(tr_last), .tr_code(tr_code),
    .tr_done(tr_done), .busy(busy), .cfg_err(cfg_err),
    .cpl_valid(cpl_valid), .cpl_code(cpl_code));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_job(input bit ab, input int b, input int c, input bit fe,
                         input bit ie, input bit early, input logic [5:0] code,
                         input int rmod, input int dmod, input bit restart,
                         input string cnt_req, input string ev_req);
    int total = ab ? c : b * c;
    int exp_ev = (fe ? 1 : 0) + (ie ? total - 1 : 0);
    int issued = 0, acked = 0, ev = 0, post = 0, cyc = 0;
    int timing_err = 0, code_err = 0, busy_err = 0, hold_err = 0, last_err = 0;
    bit pend_fire = 0, finished = 0, hold_prev = 0, last_prev = 0;
    @(negedge clk);
    cfg_ab_sync = ab; cfg_bcnt = 16'(b); cfg_ccnt = 16'(c); cfg_code = code;
    cfg_final_en = fe; cfg_inter_en = ie; cfg_early = early; start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R11", "busy after start", busy, 1);
    while (!(finished && post >= 2) && cyc < 5000) begin
      bit rdy, dn, acc, ackd, tlast, fire, fin_now;
      if (cpl_valid !== pend_fire) timing_err++;
      if (cpl_valid === 1'b1) begin
        ev++;
        if (cpl_code !== code) code_err++;
      end
      if (busy !== !finished) busy_err++;
      if (hold_prev && (tr_valid !== 1'b1 || tr_last !== last_prev || tr_code !== code))
        hold_err++;
      if (finished) post++;
      rdy = (cyc % rmod) != (rmod - 1);
      dn  = (cyc % dmod) == 0;
      if (restart && cyc == 3) begin
        start = 1; cfg_ab_sync = 1; cfg_ccnt = 16'd1; cfg_early = ~early;
      end else begin
        start = 0;
      end
      tlast = (issued == total - 1);
      acc   = (tr_valid === 1'b1) && rdy;
      ackd  = !early && dn && (acked < issued);
      if (acc && (tr_last !== tlast)) last_err++;
      fire  = early ? (acc && (tlast ? fe : ie))
                    : (ackd && ((acked == total - 1) ? fe : ie));
      fin_now = early ? (acc && tlast) : (ackd && acked == total - 1);
      if (acc) issued++;
      if (ackd) acked++;
      hold_prev = (tr_valid === 1'b1) && !rdy;
      last_prev = tr_last;
      pend_fire = fire;
      if (fin_now) finished = 1;
      tr_ready = rdy; tr_done = dn;
      @(negedge clk);
      cyc++;
    end
    tr_ready = 0; tr_done = 0; start = 0;
    check(issued == total, cnt_req, "accepted requests", issued, total);
    check(ev == exp_ev, ev_req, "event count", ev, exp_ev);
    check(timing_err == 0, early ? "R7" : "R8", "event timing mismatches", timing_err, 0);
    check(code_err == 0, "R9", "event code mismatches", code_err, 0);
    check(busy_err == 0, "R11", "busy mismatches", busy_err, 0);
    check(hold_err == 0, "R12", "payload hold violations", hold_err, 0);
    check(last_err == 0, "R3", "last-flag mismatches", last_err, 0);
  endtask

  task automatic zero_cfg(input int b, input int c);
    @(negedge clk);
    cfg_bcnt = 16'(b); cfg_ccnt = 16'(c); cfg_ab_sync = 0; start = 1;
    @(negedge clk);
    start = 0;
    check(cfg_err === 1'b1, "R10", "error pulse", cfg_err, 1);
    check(busy === 1'b0 && tr_valid === 1'b0, "R10", "busy/valid after bad start",
          {busy, tr_valid}, 0);
    @(negedge clk);
    check(cfg_err === 1'b0, "R10", "error pulse length", cfg_err, 0);
  endtask

  task automatic reset_check();
    check({busy, tr_valid, cpl_valid, cfg_err} === 4'b0, "R13", "outputs after reset",
          {busy, tr_valid, cpl_valid, cfg_err}, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished_run) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1;
    @(negedge clk);
    reset_check();
    run_job(0, 4, 5, 1, 0, 1, 6'd30, 3, 2, 0, "R1", "R4");
    run_job(0, 4, 5, 0, 1, 0, 6'd30, 4, 2, 0, "R1", "R5");
    run_job(0, 4, 5, 1, 1, 1, 6'd17, 5, 3, 0, "R1", "R6");
    run_job(1, 4, 5, 1, 0, 0, 6'd63, 2, 3, 0, "R2", "R4");
    run_job(1, 4, 5, 0, 1, 1, 6'd1,  7, 2, 0, "R2", "R5");
    run_job(1, 4, 5, 1, 1, 0, 6'd42, 3, 1, 0, "R2", "R6");
    run_job(0, 3, 2, 1, 1, 0, 6'd9,  4, 5, 1, "R11", "R6");
    run_job(0, 1, 1, 1, 1, 1, 6'd5,  2, 2, 0, "R3", "R6");
    zero_cfg(0, 5);
    zero_cfg(4, 0);
    finished_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule